// File: doc/BRIEF.md
# Audio Card Interrupt Status and Control Register

This block is the single host-visible register of an audio expansion card. It sits between the host bus and the card's sample datapath. A read strobe returns one status byte, and a write strobe at the same location loads control bits. The status byte gathers the audio codec interrupt, the serial port interrupt, and the level flags of the playback and capture sample FIFOs. The combined interrupt line tells the host when to move a block of samples into or out of those FIFOs.

The control byte switches codec transfers out of the playback FIFO and into the capture FIFO. It also masks the codec and serial interrupts, and it can request a flush of the datapath. A flush request gives a single-cycle pulse and stops both transfer paths. All four interrupt sources arrive without a fixed timing relation to the clock, so they pass through a synchronizer with `SYNC_STAGES` flops before any logic uses them. The codec interrupt is latched and stays pending until the host reads the status byte.

Top module: `audio_irq_ctrl`

## Requirements
- R1: Status bit 1 shows the latched codec interrupt, status bit 2 shows the synchronized serial-port interrupt level, and status bits 3, 4 and 5 always read 0.
- R2: Status bit 6 shows the synchronized playback-FIFO half-empty flag and is 1 while that flag is high.
- R3: Status bit 7 shows the synchronized capture-FIFO half-full flag inverted, so it reads 0 while the capture FIFO is at least half full.
- R4: `host_irq` equals status bit 0. Both are 1 exactly when at least one of these holds: the codec latch is set and the codec enable (control bit 1) is set; the serial level is high and the serial enable (control bit 2) is set; the playback half-empty flag is high and playback transfers are enabled; the capture half-full flag is high and capture transfers are enabled.
- R5: A write without bit 7 set loads control bit 3 into `play_xfer_en`, bit 4 into `cap_xfer_en`, and bits 1 and 2 into the codec and serial interrupt enables, replacing their earlier values. Bits 0, 5 and 6 are ignored.
- R6: A write with bit 7 set drives `fifo_flush` high for exactly the one cycle after the write and clears both transfer enables, whatever bits 3 and 4 hold. Bits 1 and 2 still load the interrupt enables, and bit 7 is not kept.
- R7: A read clears the codec latch, unless the synchronized codec interrupt is still high in that cycle. A read changes no other status bit and no control bit.
- R8: During reset and right after it, all control bits and the codec latch are 0, and `host_irq` and `fifo_flush` are low. The synchronizers also reset to 0, so status reads 0x80 until real flag values have passed through.
- R9: Once the codec latch is set, it stays set after the codec input drops, until a read clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_rd | input | 1 | Status read strobe, one cycle per access |
| host_wr | input | 1 | Control write strobe, one cycle per access |
| host_wdata | input | 8 | Control byte written by the host |
| host_rdata | output | 8 | Status byte |
| codec_irq | input | 1 | Codec interrupt request, asynchronous |
| uart_irq | input | 1 | Serial port interrupt request, asynchronous level |
| play_half_empty | input | 1 | Playback FIFO is at most half full |
| cap_half_full | input | 1 | Capture FIFO is at least half full |
| host_irq | output | 1 | Combined active-high interrupt to the host |
| play_xfer_en | output | 1 | Enables codec reads from the playback FIFO |
| cap_xfer_en | output | 1 | Enables codec writes into the capture FIFO |
| fifo_flush | output | 1 | One-cycle pulse that flushes both FIFOs |

## Verification
The bench aims at the inverted capture flag. A design that passed this flag through without inverting it would report a full capture FIFO as needing service. The bench also issues a flush write that has both enable bits set. A design that let those bits through would keep streaming after the flush, and one that stored bit 7 would flush forever. The codec latch is tested three ways: left unread long after its input drops, read while its input is still high, and read again once the input is low. A wrong design would lose the interrupt early, drop a live request, or never acknowledge it. The bench also raises the FIFO flags while the matching enables are off, to catch a master interrupt that ignores its masks.

// File: rtl/aic_pkg.sv
package aic_pkg;
    localparam int REG_W       = 8;
    localparam int SRC_N       = 4;

    // status byte bit positions
    localparam int ST_MASTER   = 0;
    localparam int ST_CODEC    = 1;
    localparam int ST_UART     = 2;
    localparam int ST_PAD_LO   = 3;
    localparam int ST_PAD_HI   = 5;
    localparam int ST_PLAY_HE  = 6;
    localparam int ST_CAP_HFN  = 7;

    // control byte bit positions
    localparam int CT_CODEC_IE = 1;
    localparam int CT_UART_IE  = 2;
    localparam int CT_PLAY_EN  = 3;
    localparam int CT_CAP_EN   = 4;
    localparam int CT_FLUSH    = 7;

    // index of each source in the synchronized source vector
    typedef enum logic [1:0] {
        SRC_CODEC = 2'd0,
        SRC_UART  = 2'd1,
        SRC_PLAY  = 2'd2,
        SRC_CAP   = 2'd3
    } src_e;

    typedef struct packed {
        logic codec_ie;
        logic uart_ie;
        logic play_en;
        logic cap_en;
    } ctrl_t;
endpackage

// File: rtl/aic_sync.sv
module aic_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] chain_d [STAGES];
    logic [WIDTH-1:0] chain_q [STAGES];

    always_comb begin
        chain_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain_q[g] <= '0;
                end else begin
                    chain_q[g] <= chain_d[g];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[LAST];
endmodule

// File: rtl/aic_ctrl.sv
module aic_ctrl
    import aic_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output ctrl_t            ctrl,
    output logic             flush
);
    typedef struct packed {
        ctrl_t ctrl;
        logic  flush;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    // bits without a function are discarded
    logic unused_wbits;
    assign unused_wbits = ^{wdata[0], wdata[6:5]};

    always_comb begin
        st_d       = st_q;
        st_d.flush = 1'b0;
        if (wr) begin
            st_d.ctrl.codec_ie = wdata[CT_CODEC_IE];
            st_d.ctrl.uart_ie  = wdata[CT_UART_IE];
            st_d.ctrl.play_en  = wdata[CT_PLAY_EN];
            st_d.ctrl.cap_en   = wdata[CT_CAP_EN];
            if (wdata[CT_FLUSH]) begin
                st_d.ctrl.play_en = 1'b0;
                st_d.ctrl.cap_en  = 1'b0;
                st_d.flush        = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl  = st_q.ctrl;
    assign flush = st_q.flush;
endmodule

// File: rtl/aic_status.sv
module aic_status
    import aic_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd,
    input  logic [SRC_N-1:0] src,
    input  ctrl_t            ctrl,
    output logic [REG_W-1:0] status,
    output logic             irq
);
    typedef struct packed {
        logic codec_latch;
    } stat_state_t;

    stat_state_t st_d, st_q;
    logic [SRC_N-1:0] pend;

    always_comb begin
        st_d = st_q;
        if (rd) begin
            st_d.codec_latch = 1'b0;
        end
        if (src[SRC_CODEC]) begin
            st_d.codec_latch = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        pend[SRC_CODEC] = st_q.codec_latch & ctrl.codec_ie;
        pend[SRC_UART]  = src[SRC_UART]    & ctrl.uart_ie;
        pend[SRC_PLAY]  = src[SRC_PLAY]    & ctrl.play_en;
        pend[SRC_CAP]   = src[SRC_CAP]     & ctrl.cap_en;
        irq             = |pend;
    end

    always_comb begin
        status                        = '0;
        status[ST_MASTER]             = irq;
        status[ST_CODEC]              = st_q.codec_latch;
        status[ST_UART]               = src[SRC_UART];
        status[ST_PAD_HI:ST_PAD_LO]   = '0;
        status[ST_PLAY_HE]            = src[SRC_PLAY];
        status[ST_CAP_HFN]            = ~src[SRC_CAP];
    end
endmodule

// File: rtl/audio_irq_ctrl.sv
module audio_irq_ctrl
    import aic_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_rd,
    input  logic       host_wr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    input  logic       codec_irq,
    input  logic       uart_irq,
    input  logic       play_half_empty,
    input  logic       cap_half_full,
    output logic       host_irq,
    output logic       play_xfer_en,
    output logic       cap_xfer_en,
    output logic       fifo_flush
);
    logic [SRC_N-1:0] src_raw;
    logic [SRC_N-1:0] src_sync;
    ctrl_t            ctrl;

    always_comb begin
        src_raw            = '0;
        src_raw[SRC_CODEC] = codec_irq;
        src_raw[SRC_UART]  = uart_irq;
        src_raw[SRC_PLAY]  = play_half_empty;
        src_raw[SRC_CAP]   = cap_half_full;
    end

    aic_sync #(
        .WIDTH  (SRC_N),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (src_raw),
        .sync_out (src_sync)
    );

    aic_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (host_wr),
        .wdata (host_wdata),
        .ctrl  (ctrl),
        .flush (fifo_flush)
    );

    aic_status u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd     (host_rd),
        .src    (src_sync),
        .ctrl   (ctrl),
        .status (host_rdata),
        .irq    (host_irq)
    );

    assign play_xfer_en = ctrl.play_en;
    assign cap_xfer_en  = ctrl.cap_en;
endmodule

// File: rtl/audio_irq_ctrl_chk.sv
module audio_irq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       host_rd,
    input logic       host_wr,
    input logic [7:0] host_wdata,
    input logic [7:0] host_rdata,
    input logic       codec_irq,
    input logic       uart_irq,
    input logic       play_half_empty,
    input logic       cap_half_full,
    input logic       host_irq,
    input logic       play_xfer_en,
    input logic       cap_xfer_en,
    input logic       fifo_flush
);
    // R1
    pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdata[5:3] == 3'b000);

    // R4
    master_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq == host_rdata[0]);

    // R4
    irq_needs_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!play_xfer_en && !cap_xfer_en && !host_rdata[1] && !host_rdata[2]) |-> !host_irq);

    // R5
    ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !host_wdata[7]) |=>
            (play_xfer_en == $past(host_wdata[3]) && cap_xfer_en == $past(host_wdata[4])));

    // R6
    flush_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flush |=> !fifo_flush);

    // R6
    flush_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flush |-> (!play_xfer_en && !cap_xfer_en));

    // R9
    codec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rdata[1] && !host_rd) |=> host_rdata[1]);
endmodule

bind audio_irq_ctrl audio_irq_ctrl_chk u_chk (.*);

// File: tb/audio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module audio_irq_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_rd = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       codec_irq = 1'b0;
    logic       uart_irq = 1'b0;
    logic       play_half_empty = 1'b0;
    logic       cap_half_full = 1'b1;
    logic       host_irq;
    logic       play_xfer_en;
    logic       cap_xfer_en;
    logic       fifo_flush;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    audio_irq_ctrl u_audio_irq_ctrl (.*);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1;
        host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
        host_wdata = '0;
    endtask

    task automatic bus_read(output logic [7:0] d);
        @(negedge clk);
        host_rd = 1'b1;
        d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        idle(3);
        chk("R8 status in reset", host_rdata, 8'h80);
        chk("R8 outputs in reset", {4'b0, host_irq, play_xfer_en, cap_xfer_en, fifo_flush}, 8'h00);
        rst_n = 1'b1;
        idle(5);
        chk("R8 status after reset", host_rdata, 8'h00);
        chk("R8 outputs after reset", {4'b0, host_irq, play_xfer_en, cap_xfer_en, fifo_flush}, 8'h00);
    endtask

    task automatic t_flags;
        play_half_empty = 1'b1;
        idle(4);
        chk("R2 playback half empty", host_rdata, 8'h40);
        chk("R4 masked playback flag", {7'b0, host_irq}, 8'h00);
        cap_half_full = 1'b0;
        idle(4);
        chk("R3 capture below half", host_rdata, 8'hC0);
        play_half_empty = 1'b0;
        cap_half_full = 1'b1;
        idle(4);
        chk("R3 capture at half", host_rdata, 8'h00);
    endtask

    task automatic t_enables;
        play_half_empty = 1'b1;
        idle(4);
        bus_write(8'h79);
        chk("R5 both enables, ignored bits", {6'b0, play_xfer_en, cap_xfer_en}, 8'h03);
        chk("R4 playback source", host_rdata, 8'h41);
        bus_write(8'h10);
        chk("R5 capture only", {6'b0, play_xfer_en, cap_xfer_en}, 8'h01);
        chk("R4 capture full no flag", {7'b0, host_irq}, 8'h01);
        cap_half_full = 1'b0;
        idle(4);
        chk("R4 nothing pending", host_rdata, 8'hC0);
        cap_half_full = 1'b1;
        play_half_empty = 1'b0;
        idle(4);
    endtask

    task automatic t_flush;
        bus_write(8'h18);
        bus_write(8'h9E);
        chk("R6 flush pulse and enables", {4'b0, fifo_flush, play_xfer_en, cap_xfer_en, 1'b0}, 8'h08);
        @(negedge clk);
        chk("R6 flush lasts one cycle", {7'b0, fifo_flush}, 8'h00);
        uart_irq = 1'b1;
        idle(4);
        chk("R6 serial enable kept by flush write", {7'b0, host_irq}, 8'h01);
        uart_irq = 1'b0;
        bus_write(8'h00);
        idle(4);
    endtask

    task automatic t_codec;
        logic [7:0] r;
        bus_write(8'h02);
        @(negedge clk);
        codec_irq = 1'b1;
        idle(2);
        codec_irq = 1'b0;
        idle(5);
        chk("R1 codec latched", host_rdata, 8'h03);
        idle(20);
        chk("R9 codec held", host_rdata, 8'h03);
        bus_read(r);
        chk("R7 read returns pending", r, 8'h03);
        chk("R7 read clears latch", host_rdata, 8'h00);
        codec_irq = 1'b1;
        idle(5);
        bus_read(r);
        chk("R7 live source survives read", host_rdata, 8'h03);
        codec_irq = 1'b0;
        idle(4);
        bus_read(r);
        chk("R7 cleared after drop", host_rdata, 8'h00);
    endtask

    task automatic t_uart;
        logic [7:0] r;
        uart_irq = 1'b1;
        play_half_empty = 1'b1;
        idle(4);
        chk("R1 serial level masked", host_rdata, 8'h44);
        bus_write(8'h04);
        chk("R4 serial enabled", host_rdata, 8'h45);
        bus_read(r);
        chk("R7 read leaves levels", host_rdata, 8'h45);
        chk("R7 read leaves control", {6'b0, play_xfer_en, cap_xfer_en}, 8'h00);
        uart_irq = 1'b0;
        idle(4);
        chk("R1 serial dropped", host_rdata, 8'h40);
    endtask

    task automatic t_midrun_reset;
        bus_write(8'h18);
        @(negedge clk);
        rst_n = 1'b0;
        idle(2);
        chk("R8 control cleared by reset", {6'b0, play_xfer_en, cap_xfer_en}, 8'h00);
        rst_n = 1'b1;
        idle(5);
        chk("R8 irq low after reset", {7'b0, host_irq}, 8'h00);
    endtask

    initial begin
        #400000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_flags();
        t_enables();
        t_flush();
        t_codec();
        t_uart();
        t_midrun_reset();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule